// File: doc/BRIEF.md
# Per-Pin GPIO Controller with Interrupt Summary

This block controls a bank of general-purpose pins in which every pin owns a 32-bit control and status word. Software reaches the words over a simple memory-mapped register bus. A word holds the pin's drive value, its direction, an interrupt enable, a three-bit trigger type, a reset-keep flag, a stored debounce selector, an input mask, a sticky pending flag and the synchronized pad value. Because every pin has its own word, software never needs a read-modify-write on a shared bank vector.

Each pad input passes through a two-flop synchronizer. A detector compares the synchronized sample with the previous one, or tests the level, according to the pin's trigger type. A hit sets the pin's pending flag, and software clears the flag by writing 1 to it. The pending flags are also collected into read-only summary words of 32 pins each, so an interrupt handler can find the active pins with one read per group. A single combined interrupt line is raised while any enabled, unmasked pin has its pending flag set. A synchronous soft reset returns every pin to its idle state, except pins whose reset-keep flag is set.

Top module: `pinctl_bank`

## Requirements
- R1: After the hard reset every control word reads 0, every summary word reads 0, `pad_oe` and `pad_out` are all 0 and `irq` is 0.
- R2: The word for pin n is at byte address 0x180 + 4*n. Bit 0 is the drive value, bit 1 is the direction (1 = drive), bit 2 is the interrupt enable, bits 5:3 are the trigger type, bit 6 is the reset-keep flag, bits 8:7 are the debounce selector and bit 9 is the input mask. All of these read back as written. Bits 10, 11 and 14 to 31 read as 0. Bit 12 is the pending flag and bit 13 the input value, and neither can be set by a write.
- R3: `pad_oe[n]` equals bit 1 and `pad_out[n]` equals bit 0 of pin n's word from the clock edge that accepts the write. A single write that sets both bits makes the pin drive the new value in the same cycle that the driver turns on.
- R4: Bit 13 shows the pad through a two-flop synchronizer, even while the pin drives. For a pad change made between edges e-1 and e0, reads accepted at e0 and e1 return the old value and a read accepted at e2 returns the new value.
- R5: The trigger type, written as bits {5,4,3}, selects the event: 000 falling edge, 001 rising edge, 101 either edge, 010 low level, 011 high level. Edges are found between successive synchronized samples. Any detected event sets the pending flag, whatever the interrupt enable.
- R6: Writing a word with bit 12 = 1 clears that pin's pending flag, and bit 12 = 0 leaves it unchanged. When an edge event and a clearing write fall on the same clock edge, the flag stays set.
- R7: In a level mode whose condition still holds, a clearing write drops the flag for exactly one cycle. A read accepted on the next edge returns 0, and one accepted on the edge after that returns 1.
- R8: The summary word for group g is read at 0x100 + 4*g, and its bit p equals the pending flag of pin 32*g + p. Bits of pins that do not exist read 0, and writes to summary words have no effect.
- R9: `irq` is 1 exactly when some pin has its pending flag, its interrupt enable set and its input mask clear.
- R10: A pin whose input mask is set never gets its pending flag set by pad activity.
- R11: A one-cycle `soft_rst` clears the whole word of every pin whose reset-keep flag is clear, and leaves the words of the other pins unchanged.
- R12: Reads of unmapped or misaligned addresses return 0, and writes to them change no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset that spares pins with the reset-keep flag set |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is valid after the next clock edge |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS (40) | Raw pad inputs |
| pad_out | output | NUM_PINS (40) | Pad drive values |
| pad_oe | output | NUM_PINS (40) | Pad drive enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench goes after the same-edge collision between an edge event and a clearing write. A design that gives the clear priority would lose that edge, and the pending flag would read 0. It also checks the one-cycle dip of a level-mode flag after a clear. A design that keeps the flag set would show no dip, and one that never re-arms would stay at 0. The exact synchronizer delay of the input bit is measured to the cycle, so a missing or extra flop shows up as the new value arriving one read early or late. The bench then exercises the five trigger encodings in both directions, masked pins, the enable gating of `irq`, the summary bits of the second, partly filled group, and a soft reset that must spare only the pins with the reset-keep flag.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

  localparam logic [31:0] CTRL_BASE = 32'h180;
  localparam logic [31:0] SUM_BASE  = 32'h100;
  localparam int          STS_BIT   = 12;
  localparam int          DIN_BIT   = 13;

  // Field order is the bit order of a control word (bit 0 = drive value).
  typedef struct packed {
    logic       in_mask;   // bit 9
    logic [1:0] db_sel;    // bits 8:7
    logic       keep;      // bit 6
    logic [2:0] trig;      // bits 5:3
    logic       ien;       // bit 2
    logic       dir;       // bit 1
    logic       dout;      // bit 0
  } pin_cfg_t;

  localparam int CFG_W = $bits(pin_cfg_t);

  // A type with bit 1 set is a level mode; bit 0 selects its polarity.
  function automatic logic is_level(input logic [2:0] trig);
    return trig[1];
  endfunction

  // Detects the event chosen by the trigger type on one synchronized pin.
  function automatic logic trig_hit(input logic [2:0] trig,
                                    input logic cur, input logic prev);
    if (trig[1])      return cur == trig[0];
    else if (trig[2]) return cur != prev;
    else if (trig[0]) return cur & ~prev;
    else              return ~cur & prev;
  endfunction

  function automatic logic [31:0] pack_word(input pin_cfg_t cfg,
                                            input logic pend, input logic din);
    logic [31:0] w;
    w = '0;
    w[CFG_W-1:0] = cfg;
    w[STS_BIT]   = pend;
    w[DIN_BIT]   = din;
    return w;
  endfunction

endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
  parameter int WIDTH  = 40,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);

  // Stages 0..STAGES-1 form the synchronizer; the last stage holds the
  // previous synchronized sample for edge detection.
  logic [WIDTH-1:0] stage [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k <= STAGES; k++) stage[k] <= '0;
    end else begin
      stage[0] <= din;
      for (int k = 1; k <= STAGES; k++) stage[k] <= stage[k-1];
    end
  end

  assign cur  = stage[STAGES-1];
  assign prev = stage[STAGES];

endmodule

// File: rtl/pinctl_decode.sv
module pinctl_decode #(
  parameter int NUM_PINS = 40,
  parameter int NUM_GRP  = 2,
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 6,
  parameter int GRP_W    = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ctrl_hit,
  output logic [IDX_W-1:0]  ctrl_idx,
  output logic              sum_hit,
  output logic [GRP_W-1:0]  sum_idx
);
  import pinctl_pkg::*;

  localparam logic [31:0] CTRL_END = CTRL_BASE + 32'(4 * NUM_PINS);
  localparam logic [31:0] SUM_END  = SUM_BASE + 32'(4 * NUM_GRP);

  logic [31:0] a, ctrl_off, sum_off;
  logic        aligned;

  assign a        = 32'(addr);
  assign aligned  = (a[1:0] == 2'b00);
  assign ctrl_off = a - CTRL_BASE;
  assign sum_off  = a - SUM_BASE;

  assign ctrl_hit = aligned && (a >= CTRL_BASE) && (a < CTRL_END);
  assign sum_hit  = aligned && (a >= SUM_BASE) && (a < SUM_END);
  assign ctrl_idx = IDX_W'(ctrl_off >> 2);
  assign sum_idx  = GRP_W'(sum_off >> 2);

endmodule

// File: rtl/pinctl_pin.sv
module pinctl_pin
  import pinctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        wr_sel,
  input  pin_cfg_t    wr_cfg,
  input  logic        wr_clr,
  input  logic        cur,
  input  logic        prev,
  output logic [31:0] word,
  output logic        drv_val,
  output logic        drv_en,
  output logic        pend_o,
  output logic        irq_req
);

  pin_cfg_t cfg;
  logic     pend;

  // Named internal events, used by the update logic and the assertions.
  logic hit, edge_hit, level_hit, clr_now;

  assign hit       = trig_hit(cfg.trig, cur, prev) & ~cfg.in_mask;
  assign edge_hit  = hit & ~is_level(cfg.trig);
  assign level_hit = hit & is_level(cfg.trig);
  assign clr_now   = wr_sel & wr_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      pend <= 1'b0;
    end else if (soft_rst) begin
      if (!cfg.keep) begin
        cfg  <= '0;
        pend <= 1'b0;
      end
    end else begin
      if (wr_sel) cfg <= wr_cfg;
      // An edge wins over a same-cycle clear; a level is re-tested next cycle.
      pend <= edge_hit | ((pend | level_hit) & ~clr_now);
    end
  end

  assign word    = pack_word(cfg, pend, cur);
  assign drv_val = cfg.dout;
  assign drv_en  = cfg.dir;
  assign pend_o  = pend;
  assign irq_req = pend & cfg.ien & ~cfg.in_mask;

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now && !edge_hit && !soft_rst |=> !pend); // R6
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit && !soft_rst |=> pend); // R6
  AST_LEVEL_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    !pend && level_hit && !wr_sel && !soft_rst |=> pend); // R7
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.in_mask && !pend && !soft_rst |=> !pend); // R10
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && !cfg.keep |=> (cfg == '0) && !pend); // R11
  AST_SOFT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && cfg.keep |=> $stable(cfg) && $stable(pend)); // R11

endmodule

// File: rtl/pinctl_bank.sv
module pinctl_bank
  import pinctl_pkg::*;
#(
  parameter int NUM_PINS    = 40,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq
);

  localparam int NUM_GRP = (NUM_PINS + 31) / 32;
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  logic             ctrl_hit, sum_hit;
  logic [IDX_W-1:0] ctrl_idx;
  logic [GRP_W-1:0] sum_idx;

  pinctl_decode #(
    .NUM_PINS(NUM_PINS), .NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W),
    .IDX_W(IDX_W), .GRP_W(GRP_W)
  ) u_dec (
    .addr(bus_addr), .ctrl_hit(ctrl_hit), .ctrl_idx(ctrl_idx),
    .sum_hit(sum_hit), .sum_idx(sum_idx)
  );

  logic [NUM_PINS-1:0] cur, prev, pend_vec, irq_vec;

  pinctl_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .cur(cur), .prev(prev)
  );

  pin_cfg_t    wr_cfg;
  logic        wr_clr;
  logic [31:0] word [NUM_PINS];

  assign wr_cfg = pin_cfg_t'(bus_wdata[CFG_W-1:0]);
  assign wr_clr = bus_wdata[STS_BIT];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic sel;
    assign sel = bus_wr & ctrl_hit & (ctrl_idx == IDX_W'(i));
    pinctl_pin u_pin (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_sel(sel), .wr_cfg(wr_cfg), .wr_clr(wr_clr),
      .cur(cur[i]), .prev(prev[i]),
      .word(word[i]), .drv_val(pad_out[i]), .drv_en(pad_oe[i]),
      .pend_o(pend_vec[i]), .irq_req(irq_vec[i])
    );
  end

  // Summary words: bit p of group g mirrors the pending flag of pin 32g+p.
  logic [31:0] sum_word [NUM_GRP];
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    for (genvar p = 0; p < 32; p++) begin : g_bit
      if (g * 32 + p < NUM_PINS) begin : g_real
        assign sum_word[g][p] = pend_vec[g*32+p];
      end else begin : g_pad
        assign sum_word[g][p] = 1'b0;
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (ctrl_hit)     rd_mux = word[ctrl_idx];
    else if (sum_hit) rd_mux = sum_word[sum_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign irq = |irq_vec;

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[31:DIN_BIT], bus_wdata[STS_BIT-1:CFG_W]};

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|pend_vec)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !ctrl_hit && !sum_hit |=> bus_rdata == '0); // R12

endmodule

// File: tb/pinctl_bank_test.sv
module pinctl_bank_test;

  localparam int N = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  pinctl_bank uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [11:0] ca(input int n);
    return 12'(12'h180 + 4 * n);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(ca(0), d);      chk("R1 word0", d, 32'h0);
    rd(ca(N-1), d);    chk("R1 last word", d, 32'h0);
    rd(12'h104, d);    chk("R1 summary", d, 32'h0);
    chk("R1 pad_oe", 32'(pad_oe), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(ca(7), 32'hFFFF_FFFF);
    rd(ca(7), d);  chk("R2 writable fields", d, 32'h0000_03FF);
    wr(ca(7), 32'h0000_0180);
    rd(ca(7), d);  chk("R2 debounce selector", d, 32'h0000_0180);
    wr(ca(7), 32'h0000_2000);
    rd(ca(7), d);  chk("R2 input bit not writable", d, 32'h0);
  endtask

  task automatic t_output();
    logic [31:0] d;
    wr(ca(5), 32'h0);
    chk("R3 idle oe", 32'(pad_oe[5]), 32'h0);
    wr(ca(5), 32'h3);
    chk("R3 oe on", 32'(pad_oe[5]), 32'h1);
    chk("R3 value with oe", 32'(pad_out[5]), 32'h1);
    rd(ca(5), d);  chk("R4 input shows pad not drive", d, 32'h3);
    wr(ca(5), 32'h2);
    chk("R3 drive low", 32'(pad_out[5]), 32'h0);
  endtask

  task automatic t_sync();
    logic [31:0] d;
    wr(ca(6), 32'h200);
    idle(2);
    pad_in[6] = 1'b1;
    rd(ca(6), d);  chk("R4 read at e0", d, 32'h200);
    rd(ca(6), d);  chk("R4 read at e1", d, 32'h200);
    rd(ca(6), d);  chk("R4 read at e2", d, 32'h2200);
  endtask

  task automatic trig_case(input string req, input logic [2:0] t,
                           input logic p0, input logic p1, input logic exp);
    logic [31:0] d, cfg;
    cfg = {26'b0, t, 3'b100};
    pad_in[10] = p0;
    wr(ca(10), cfg);
    idle(5);
    wr(ca(10), cfg | 32'h1000);
    idle(2);
    pad_in[10] = p1;
    idle(6);
    rd(ca(10), d);
    chk(req, 32'(d[12]), 32'(exp));
    chk({req, " irq"}, 32'(irq), 32'(exp));
  endtask

  task automatic t_triggers();
    trig_case("R5 rise on rise", 3'b001, 1'b0, 1'b1, 1'b1);
    trig_case("R5 rise on fall", 3'b001, 1'b1, 1'b0, 1'b0);
    trig_case("R5 fall on fall", 3'b000, 1'b1, 1'b0, 1'b1);
    trig_case("R5 fall on rise", 3'b000, 1'b0, 1'b1, 1'b0);
    trig_case("R5 both on rise", 3'b101, 1'b0, 1'b1, 1'b1);
    trig_case("R5 both on fall", 3'b101, 1'b1, 1'b0, 1'b1);
    trig_case("R5 high level",   3'b011, 1'b0, 1'b1, 1'b1);
    trig_case("R5 high idle",    3'b011, 1'b0, 1'b0, 1'b0);
    trig_case("R5 low level",    3'b010, 1'b1, 1'b0, 1'b1);
    trig_case("R5 low idle",     3'b010, 1'b1, 1'b1, 1'b0);
    wr(ca(10), 32'h1000);
    pad_in[10] = 1'b0;
    idle(5);
    wr(ca(10), 32'h1000);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(ca(11), 32'h28);
    idle(4);
    pad_in[11] = 1'b1;
    idle(6);
    wr(ca(11), 32'h28);
    rd(ca(11), d);  chk("R6 zero write keeps flag", 32'(d[12]), 32'h1);
    wr(ca(11), 32'h1028);
    rd(ca(11), d);  chk("R6 clear", 32'(d[12]), 32'h0);
    pad_in[11] = 1'b0;
    idle(6);
    // Edge event and clearing write on the same clock edge.
    pad_in[11] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b1; bus_addr = ca(11); bus_wdata = 32'h1028;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
    rd(ca(11), d);  chk("R6 edge beats clear", 32'(d[12]), 32'h1);
    wr(ca(11), 32'h1028);
    rd(ca(11), d);  chk("R6 clear after race", 32'(d[12]), 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    pad_in[12] = 1'b1;
    wr(ca(12), 32'h18);
    idle(5);
    rd(ca(12), d);  chk("R7 level set", 32'(d[12]), 32'h1);
    wr(ca(12), 32'h1018);
    rd(ca(12), d);  chk("R7 dip after clear", 32'(d[12]), 32'h0);
    rd(ca(12), d);  chk("R7 rearm", 32'(d[12]), 32'h1);
    pad_in[12] = 1'b0;
    idle(5);
    wr(ca(12), 32'h1018);
    idle(2);
    rd(ca(12), d);  chk("R7 stays clear when level gone", 32'(d[12]), 32'h0);
    wr(ca(12), 32'h0);
  endtask

  task automatic t_summary();
    logic [31:0] d;
    wr(ca(33), 32'h08);
    idle(3);
    pad_in[33] = 1'b1;
    idle(6);
    rd(12'h104, d);  chk("R8 group1 bit", d, 32'h2);
    rd(12'h100, d);  chk("R8 group0 empty", d, 32'h0);
    wr(12'h104, 32'hFFFF_FFFF);
    rd(12'h104, d);  chk("R8 write ignored", d, 32'h2);
    pad_in[3] = 1'b1;
    idle(5);
    pad_in[3] = 1'b0;
    idle(6);
    rd(12'h100, d);  chk("R8 group0 bit3", d, 32'h8);
    wr(ca(3), 32'h1000);
    wr(ca(33), 32'h1008);
    rd(12'h100, d);  chk("R8 cleared g0", d, 32'h0);
    rd(12'h104, d);  chk("R8 cleared g1", d, 32'h0);
  endtask

  task automatic t_irq_mask();
    logic [31:0] d;
    wr(ca(20), 32'h0C);
    idle(3);
    pad_in[20] = 1'b1;
    idle(6);
    chk("R9 irq on enabled flag", 32'(irq), 32'h1);
    wr(ca(20), 32'h20C);
    chk("R9 mask gates irq", 32'(irq), 32'h0);
    rd(ca(20), d);  chk("R10 flag kept under mask", d, 32'h320C);
    wr(ca(20), 32'h120C);
    pad_in[20] = 1'b0;
    idle(4);
    pad_in[20] = 1'b1;
    idle(6);
    rd(ca(20), d);  chk("R10 masked edge ignored", 32'(d[12]), 32'h0);
    chk("R10 no irq", 32'(irq), 32'h0);
    wr(ca(20), 32'h0);
    wr(ca(21), 32'h08);
    idle(3);
    pad_in[21] = 1'b1;
    idle(6);
    rd(ca(21), d);  chk("R5 flag without enable", 32'(d[12]), 32'h1);
    chk("R9 no irq without enable", 32'(irq), 32'h0);
    wr(ca(21), 32'h1000);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    wr(ca(1), 32'h1C3);
    wr(ca(2), 32'h103);
    soft_rst = 1'b1;
    @(posedge clk); @(negedge clk);
    soft_rst = 1'b0;
    rd(ca(1), d);  chk("R11 kept word", d, 32'h1C3);
    rd(ca(2), d);  chk("R11 cleared word", d, 32'h0);
    chk("R11 kept driver", 32'(pad_oe[1]), 32'h1);
    chk("R11 cleared driver", 32'(pad_oe[2]), 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(12'h220, d);  chk("R12 past last word", d, 32'h0);
    rd(12'h108, d);  chk("R12 past last group", d, 32'h0);
    rd(12'h17C, d);  chk("R12 gap", d, 32'h0);
    rd(12'h181, d);  chk("R12 misaligned", d, 32'h0);
    wr(12'h220, 32'h3);
    wr(12'h181, 32'h3);
    rd(ca(0), d);    chk("R12 stray writes", d, 32'h0);
    chk("R12 no drivers", 32'(pad_oe[0]), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_layout();
    t_output();
    t_sync();
    t_triggers();
    t_w1c();
    t_level();
    t_summary();
    t_irq_mask();
    t_soft();
    t_unmapped();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule